// File: doc/BRIEF.md
# Initialization Block Fetch Sequencer

This block sits inside a bus-mastering network controller. It loads the controller's working parameters from a small block in host memory. Software first places a 24-bit pointer into two control fields: a 16-bit low half and an 8-bit high half. It then issues an init command. The sequencer reads five consecutive 16-bit words from that address through a simple request/acknowledge read port. It steers each word into the parameter registers. Only after the last register has been written does it raise a sticky init-done flag. An interrupt request follows that flag when the global interrupt enable is set.

Software may instead fill the parameter registers itself through a direct write port, and skip the memory fetch. A later init command still overwrites those values with the fetched block. A start command that arrives before or together with init is held back. The controller enters the running state only when init-done rises. A stop command, like reset, abandons a fetch that is under way.

The block in memory holds five 16-bit words. Each word goes to a fixed place:

| Word index | Address offset | Bits 15:8 | Bits 7:0 |
|---|---|---|---|
| 0 | +0 | mode word | mode word |
| 1 | +2 | receive ring base [15:8] | receive ring base [7:0] |
| 2 | +4 | receive ring length | receive ring base [23:16] |
| 3 | +6 | transmit ring base [15:8] | transmit ring base [7:0] |
| 4 | +8 | transmit ring length | transmit ring base [23:16] |

Word 0 fills all 16 bits of `mode_word`. Words 1 and 3 fill the low 16 bits of the two ring bases.

Top module: `initblk_fetch`

## Requirements
- R1: An init command seen while the sequencer is idle latches the pointer `{ptr_hi, ptr_lo}`. In the next cycle `mem_req` is high with `mem_addr` equal to that pointer.
- R2: The sequencer reads the words one after another. It holds `mem_req` with `mem_addr` unchanged until `mem_ack` arrives. After each acknowledged word that is not the last, the address advances by 2, wrapping modulo 2^24. A carry out of the low 16 bits propagates into the high 8 bits.
- R3: Each fetched word lands in its register according to the word layout table above.
- R4: Exactly five words are read. `init_done` stays low while `mem_req` is high. It rises in the cycle after the one in which `mem_req` first falls after the fifth acknowledged word.
- R5: `init_done` stays set until `done_clr` is pulsed, and that pulse clears it.
- R6: `irq` is high exactly when `init_done` and `int_en` are both high, and it follows `int_en` while `init_done` is set.
- R7: A direct write (`dw_en` high, with `dw_sel` equal to the word index in the layout table) takes effect in the next cycle while the sequencer is idle. A direct write issued during a fetch is ignored. A later init command overwrites direct-written values with the fetched ones.
- R8: A start command issued while the sequencer is idle and no init is given raises `running` in the next cycle. A start issued together with init, or during a fetch, keeps `running` low until the cycle in which `init_done` rises, and both then go high together.
- R9: A stop command drops `mem_req` and `running` in the next cycle, returns the sequencer to idle and cancels any held start. It leaves `init_done` low, and registers not yet fetched keep their old values.
- R10: An init command issued while a fetch is under way is ignored. The fetch continues from its original pointer.
- R11: After reset all parameter registers, `init_done`, `irq`, `running` and `mem_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_init | input | 1 | Init command pulse |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse, aborts a fetch |
| done_clr | input | 1 | Write-one-to-clear pulse for init-done |
| int_en | input | 1 | Global interrupt enable |
| ptr_lo | input | 16 | Block pointer, low 16 bits |
| ptr_hi | input | 8 | Block pointer, high 8 bits |
| dw_en | input | 1 | Direct register write strobe |
| dw_sel | input | 3 | Direct write word index (0 to 4) |
| dw_data | input | 16 | Direct write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory read byte address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 16 | Memory read data |
| mode_word | output | 16 | Loaded mode word |
| rx_base | output | 24 | Receive ring base address |
| tx_base | output | 24 | Transmit ring base address |
| rx_len | output | 8 | Receive ring length field |
| tx_len | output | 8 | Transmit ring length field |
| init_done | output | 1 | Sticky init-done flag |
| irq | output | 1 | Interrupt request |
| running | output | 1 | Controller started |

## Verification
The bench covers four kinds of corner case.

- **Address arithmetic.** Pointers near the top of the 24-bit space and just below a 64 KiB boundary test the carry between the two pointer halves and the wrap. A design that added only within the low half would fetch from the wrong page.
- **Memory latency.** Latencies from zero to three cycles test request holding. A sequencer that moved on without an acknowledge would skip or repeat words.
- **Timing of init-done.** The bench checks that init-done stays low during the last fetch cycle and rises exactly one cycle later. A premature flag would let software see half-loaded rings. A start arriving early must wait for that flag, or the controller would run on stale pointers.
- **Abort and re-init.** A stop must leave the flag low and ignore direct writes issued during the fetch. A second init during a fetch must be ignored, or the sequencer would restart on another pointer.

// File: rtl/initblk_pkg.sv
// Shared constants and types for the initialization block fetch sequencer.
// Assumes a five-word parameter block of bus-width words.
package initblk_pkg;
    localparam int IB_WORDS = 5;
    localparam int IB_IDX_W = $clog2(IB_WORDS);

    // Word indices inside the parameter block (also the direct-write selects)
    localparam int WI_MODE = 0;
    localparam int WI_RXLO = 1;
    localparam int WI_RXHI = 2;
    localparam int WI_TXLO = 3;
    localparam int WI_TXHI = 4;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_FIN   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/initblk_seq.sv
// Fetch sequencer: walks the parameter block one word per acknowledge.
// It drives the memory read port and produces load strobes for the
// register bank. It assumes the memory holds its data valid in the cycle
// in which it asserts mem_ack. A stop aborts from any state.
module initblk_seq
    import initblk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_init,
    input  logic                cmd_stop,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic                mem_ack,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                ld_en,
    output logic [IB_IDX_W-1:0] ld_idx,
    output logic                finish,
    output logic                busy
);
    localparam int STEP = DATA_W / 8;
    localparam logic [IB_IDX_W-1:0] LAST_IDX = IB_IDX_W'(IB_WORDS - 1);

    seq_state_e          st_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [IB_IDX_W-1:0] idx_q;

    // State, word index and address progression
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            addr_q <= '0;
            idx_q  <= '0;
        end else if (cmd_stop) begin
            st_q <= SQ_IDLE;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (cmd_init) begin
                        addr_q <= base_addr;
                        idx_q  <= '0;
                        st_q   <= SQ_FETCH;
                    end
                end
                SQ_FETCH: begin
                    if (mem_ack) begin
                        if (idx_q == LAST_IDX) begin
                            st_q <= SQ_FIN;
                        end else begin
                            idx_q  <= idx_q + 1'b1;
                            addr_q <= addr_q + ADDR_W'(STEP);
                        end
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Read port and load strobes derived from the state
    always_comb begin
        mem_req  = (st_q == SQ_FETCH);
        mem_addr = addr_q;
        ld_en    = mem_req && mem_ack && !cmd_stop;
        ld_idx   = idx_q;
        finish   = (st_q == SQ_FIN) && !cmd_stop;
        busy     = (st_q != SQ_IDLE);
    end
endmodule

// File: rtl/initblk_regs.sv
// Parameter register bank: one register per block word. Each register is
// written by the fetch or by a direct write while the sequencer is idle.
// It assumes a fetch load and a direct write never need to land in the
// same cycle; the fetch wins.
module initblk_regs
    import initblk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       busy,
    input  logic                       ld_en,
    input  logic [IB_IDX_W-1:0]        ld_idx,
    input  logic [DATA_W-1:0]          ld_data,
    input  logic                       dw_en,
    input  logic [IB_IDX_W-1:0]        dw_sel,
    input  logic [DATA_W-1:0]          dw_data,
    output logic [DATA_W-1:0]          mode_word,
    output logic [ADDR_W-1:0]          rx_base,
    output logic [ADDR_W-1:0]          tx_base,
    output logic [DATA_W-(ADDR_W-DATA_W)-1:0] rx_len,
    output logic [DATA_W-(ADDR_W-DATA_W)-1:0] tx_len
);
    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int LEN_W = DATA_W - HI_W;

    logic                wr_en;
    logic [IB_IDX_W-1:0] wr_idx;
    logic [DATA_W-1:0]   wr_data;
    logic [DATA_W-1:0]   word_bus [IB_WORDS];

    // Write port arbitration: the fetch owns the bank while busy
    always_comb begin
        wr_en   = ld_en || (dw_en && !busy);
        wr_idx  = ld_en ? ld_idx  : dw_sel;
        wr_data = ld_en ? ld_data : dw_data;
    end

    for (genvar gi = 0; gi < IB_WORDS; gi++) begin : g_word
        logic [DATA_W-1:0] q;
        // One block word register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_idx == IB_IDX_W'(gi))) begin
                q <= wr_data;
            end
        end
        assign word_bus[gi] = q;
    end

    // Field extraction from the stored words
    always_comb begin
        mode_word = word_bus[WI_MODE];
        rx_base   = {word_bus[WI_RXHI][HI_W-1:0], word_bus[WI_RXLO]};
        tx_base   = {word_bus[WI_TXHI][HI_W-1:0], word_bus[WI_TXLO]};
        rx_len    = word_bus[WI_RXHI][DATA_W-1 -: LEN_W];
        tx_len    = word_bus[WI_TXHI][DATA_W-1 -: LEN_W];
    end
endmodule

// File: rtl/initblk_status.sv
// Status logic: the sticky init-done flag, the interrupt request and the
// run state. The run state holds back a start that arrives before the
// fetch has finished. It assumes finish is a one-cycle pulse.
module initblk_status (
    input  logic clk,
    input  logic rst_n,
    input  logic finish,
    input  logic busy,
    input  logic cmd_init,
    input  logic cmd_start,
    input  logic cmd_stop,
    input  logic done_clr,
    input  logic int_en,
    output logic init_done,
    output logic irq,
    output logic running
);
    logic done_q;
    logic run_q;
    logic pend_q;
    logic defer;

    // A start must wait when a fetch is active or is being launched now
    assign defer = busy || cmd_init;

    // Sticky init-done flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
        end else if (done_clr) begin
            done_q <= 1'b0;
        end
    end

    // Run state with a held start released by finish
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_stop) begin
            run_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (finish && (pend_q || cmd_start)) begin
            run_q  <= 1'b1;
            pend_q <= 1'b0;
        end else if (cmd_start) begin
            if (defer) begin
                pend_q <= 1'b1;
            end else begin
                run_q <= 1'b1;
            end
        end
    end

    // Output mapping
    always_comb begin
        init_done = done_q;
        irq       = done_q && int_en;
        running   = run_q;
    end
endmodule

// File: rtl/initblk_fetch.sv
// Top of the initialization block fetch sequencer. It assembles the block
// pointer from its two halves and ties the sequencer, the register bank
// and the status logic together. Commands are one-cycle pulses and the
// reset is synchronous and active low.
module initblk_fetch
    import initblk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_init,
    input  logic                       cmd_start,
    input  logic                       cmd_stop,
    input  logic                       done_clr,
    input  logic                       int_en,
    input  logic [DATA_W-1:0]          ptr_lo,
    input  logic [ADDR_W-DATA_W-1:0]   ptr_hi,
    input  logic                       dw_en,
    input  logic [IB_IDX_W-1:0]        dw_sel,
    input  logic [DATA_W-1:0]          dw_data,
    output logic                       mem_req,
    output logic [ADDR_W-1:0]          mem_addr,
    input  logic                       mem_ack,
    input  logic [DATA_W-1:0]          mem_rdata,
    output logic [DATA_W-1:0]          mode_word,
    output logic [ADDR_W-1:0]          rx_base,
    output logic [ADDR_W-1:0]          tx_base,
    output logic [2*DATA_W-ADDR_W-1:0] rx_len,
    output logic [2*DATA_W-ADDR_W-1:0] tx_len,
    output logic                       init_done,
    output logic                       irq,
    output logic                       running
);
    logic [ADDR_W-1:0]   base_addr;
    logic                ld_en;
    logic [IB_IDX_W-1:0] ld_idx;
    logic                finish;
    logic                busy;

    assign base_addr = {ptr_hi, ptr_lo};

    initblk_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_init  (cmd_init),
        .cmd_stop  (cmd_stop),
        .base_addr (base_addr),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .ld_en     (ld_en),
        .ld_idx    (ld_idx),
        .finish    (finish),
        .busy      (busy)
    );

    initblk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .ld_en     (ld_en),
        .ld_idx    (ld_idx),
        .ld_data   (mem_rdata),
        .dw_en     (dw_en),
        .dw_sel    (dw_sel),
        .dw_data   (dw_data),
        .mode_word (mode_word),
        .rx_base   (rx_base),
        .tx_base   (tx_base),
        .rx_len    (rx_len),
        .tx_len    (tx_len)
    );

    initblk_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .finish    (finish),
        .busy      (busy),
        .cmd_init  (cmd_init),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .done_clr  (done_clr),
        .int_en    (int_en),
        .init_done (init_done),
        .irq       (irq),
        .running   (running)
    );
endmodule

// File: rtl/initblk_fetch_chk.sv
// Assertion checker for the fetch sequencer. It is bound to the top module
// and sees only the top's ports.
module initblk_fetch_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_stop,
    input logic              done_clr,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              init_done,
    input logic              running
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !cmd_stop) |=> (mem_req && mem_addr == $past(mem_addr))); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req && mem_ack)) |-> (mem_addr == $past(mem_addr) + STEP)); // R2

    AST_DONE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (!mem_req && $past(!mem_req))); // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !done_clr) |=> init_done); // R5

    AST_STOP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (!mem_req && !running)); // R9

    AST_RUN_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> !mem_req); // R8
endmodule

bind initblk_fetch initblk_fetch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_stop  (cmd_stop),
    .done_clr  (done_clr),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .init_done (init_done),
    .running   (running)
);

// File: tb/tb_initblk_fetch.sv
`timescale 1ns/100ps
module tb_initblk_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_init = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0;
    logic        done_clr = 1'b0, int_en = 1'b0;
    logic [15:0] ptr_lo = '0;
    logic [7:0]  ptr_hi = '0;
    logic        dw_en = 1'b0;
    logic [2:0]  dw_sel = '0;
    logic [15:0] dw_data = '0;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mode_word;
    logic [23:0] rx_base, tx_base;
    logic [7:0]  rx_len, tx_len;
    logic        init_done, irq, running;

    int n_chk = 0;
    int n_err = 0;
    int mem_lat = 0;
    bit mem_hold = 1'b0;
    int wait_cnt = 0;
    int ack_cnt = 0;
    logic [23:0] exp_base = '0;

    always #2.5 clk = ~clk;

    initblk_fetch dut (.*);

    // Vector: {base[23:0], latency[3:0], int_en}
    localparam logic [28:0] VEC [4] = '{
        {24'h012340, 4'd0, 1'b1},
        {24'hFFFFF8, 4'd2, 1'b0},
        {24'h800000, 4'd1, 1'b1},
        {24'h00FFFC, 4'd3, 1'b0}
    };

    function automatic logic [15:0] memword(input logic [23:0] a);
        return a[15:0] ^ {a[23:16], a[7:0]} ^ 16'h3C5A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory responder: acknowledges after mem_lat idle cycles and checks addresses
    initial begin
        forever begin
            @(negedge clk);
            if (!mem_req || mem_hold) begin
                mem_ack  = 1'b0;
                wait_cnt = 0;
            end else if (wait_cnt >= mem_lat) begin
                chk("R2 addr", {8'h0, mem_addr}, {8'h0, exp_base + 24'(2 * ack_cnt)});
                mem_ack   = 1'b1;
                mem_rdata = memword(mem_addr);
                ack_cnt++;
                wait_cnt = 0;
            end else begin
                mem_ack = 1'b0;
                wait_cnt++;
            end
        end
    end

    task automatic launch(input logic [23:0] base, input bit with_start);
        ptr_lo = base[15:0];
        ptr_hi = base[23:16];
        exp_base = base;
        ack_cnt = 0;
        cmd_init = 1'b1;
        cmd_start = with_start;
        @(negedge clk);
        cmd_init = 1'b0;
        cmd_start = 1'b0;
    endtask

    // Waits for the finish cycle (mem_req low after a fetch)
    task automatic wait_fin();
        for (int i = 0; i < 200; i++) begin
            if (!mem_req) break;
            if (init_done) chk("R4 done during fetch", 1, 0);
            @(negedge clk);
        end
    endtask

    task automatic check_fields(input logic [23:0] base, input string tag);
        logic [15:0] w [5];
        for (int i = 0; i < 5; i++) w[i] = memword(base + 24'(2 * i));
        chk({"R3 mode ", tag}, {16'h0, mode_word}, {16'h0, w[0]});
        chk({"R3 rx_base ", tag}, {8'h0, rx_base}, {8'h0, w[2][7:0], w[1]});
        chk({"R3 rx_len ", tag}, {24'h0, rx_len}, {24'h0, w[2][15:8]});
        chk({"R3 tx_base ", tag}, {8'h0, tx_base}, {8'h0, w[4][7:0], w[3]});
        chk({"R3 tx_len ", tag}, {24'h0, tx_len}, {24'h0, w[4][15:8]});
    endtask

    task automatic pulse_stop();
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
    endtask

    task automatic clear_done();
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk("R5 cleared", {31'h0, init_done}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 mem_req", {31'h0, mem_req}, 0);
        chk("R11 done", {31'h0, init_done}, 0);
        chk("R11 irq", {31'h0, irq}, 0);
        chk("R11 running", {31'h0, running}, 0);
        chk("R11 regs", {mode_word, rx_len, tx_len} | {8'h0, rx_base} | {8'h0, tx_base}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: direct writes in idle
        dw_en = 1'b1; dw_sel = 3'd0; dw_data = 16'hBEEF;
        @(negedge clk);
        dw_sel = 3'd4; dw_data = 16'h5012;
        @(negedge clk);
        dw_en = 1'b0;
        chk("R7 direct mode", {16'h0, mode_word}, 32'hBEEF);
        chk("R7 direct tx_len", {24'h0, tx_len}, 32'h50);
        chk("R7 direct tx_base hi", {24'h0, tx_base[23:16]}, 32'h12);

        // Vector loop: R1..R6, and R7 overwrite by fetch
        for (int v = 0; v < 4; v++) begin
            logic [23:0] base;
            bit ien;
            base = VEC[v][28:5];
            mem_lat = int'(VEC[v][4:1]);
            ien = VEC[v][0];
            int_en = ien;
            launch(base, 1'b0);
            chk("R1 req", {31'h0, mem_req}, 1);
            chk("R1 addr", {8'h0, mem_addr}, {8'h0, base});
            wait_fin();
            chk("R4 done low at finish", {31'h0, init_done}, 0);
            chk("R4 word count", ack_cnt, 5);
            @(negedge clk);
            chk("R4 done rise", {31'h0, init_done}, 1);
            check_fields(base, "vec");
            chk("R6 irq", {31'h0, irq}, {31'h0, ien});
            int_en = !ien;
            @(negedge clk);
            chk("R6 irq follows enable", {31'h0, irq}, {31'h0, !ien});
            chk("R5 sticky", {31'h0, init_done}, 1);
            int_en = 1'b0;
            clear_done();
        end

        // R8: start in idle runs next cycle
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk("R8 idle start", {31'h0, running}, 1);
        pulse_stop();
        chk("R9 stop clears running", {31'h0, running}, 0);

        // R8: start together with init waits for init-done
        mem_hold = 1'b1; mem_lat = 0;
        launch(24'h004400, 1'b1);
        repeat (3) @(negedge clk);
        chk("R8 held start", {31'h0, running}, 0);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        mem_hold = 1'b0;
        wait_fin();
        chk("R8 not running at finish", {31'h0, running}, 0);
        @(negedge clk);
        chk("R8 runs with done", {31'h0, running}, 1);
        chk("R8 done with run", {31'h0, init_done}, 1);
        pulse_stop();
        clear_done();

        // R9 and R7: abort mid-fetch, direct write during fetch ignored
        dw_en = 1'b1; dw_sel = 3'd0; dw_data = 16'h1111;
        @(negedge clk);
        dw_en = 1'b0;
        mem_hold = 1'b1;
        launch(24'h123456, 1'b1);
        dw_en = 1'b1; dw_data = 16'h2222;
        @(negedge clk);
        dw_en = 1'b0;
        pulse_stop();
        chk("R9 req dropped", {31'h0, mem_req}, 0);
        mem_hold = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 no done after abort", {31'h0, init_done}, 0);
        chk("R9 start cancelled", {31'h0, running}, 0);
        chk("R7 write during fetch ignored", {16'h0, mode_word}, 32'h1111);

        // R10: second init during fetch ignored
        mem_hold = 1'b1; mem_lat = 1;
        launch(24'h0A0B00, 1'b0);
        @(negedge clk);
        ptr_lo = 16'h7770; ptr_hi = 8'h66;
        cmd_init = 1'b1;
        @(negedge clk);
        cmd_init = 1'b0;
        mem_hold = 1'b0;
        wait_fin();
        chk("R10 word count", ack_cnt, 5);
        @(negedge clk);
        check_fields(24'h0A0B00, "R10");
        clear_done();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule